// File: doc/BRIEF.md
# Unordered Floating-Point Comparator

This block compares two 80-bit extended-precision values: the value at the top of the register stack (operand A) and a chosen stack register (operand B). The comparison is unordered. Each operand is first sorted into one class: zero, normal, denormal, infinity, quiet NaN, signaling NaN or unsupported encoding. The block then produces a three-bit condition code, an invalid-operand exception request and a write enable for the condition flags. The exception mask bit controls that enable.

The operand layout is a sign bit, then a 15-bit biased exponent, then a 64-bit significand whose top bit is an explicit integer bit. A mode input selects the ordered variant. In that mode any NaN raises invalid. The caller pulses `cmp_en_i` with both operands stable. The inputs are evaluated combinationally and the outcome is captured in registers at the same edge. The condition code register keeps its last written value whenever the flag write is suppressed.

Top module: `fcmp_unordered`

## Requirements
- R1: When A is numerically greater than B, the code {C3,C2,C0} on `cc_o` (bit 2 = C3, bit 1 = C2, bit 0 = C0) is 3'b000. This also holds for two negative values, where the one of smaller magnitude is greater.
- R2: When A is numerically less than B, the code is 3'b001. With opposite signs and not both zero, the negative operand is the lesser.
- R3: When A equals B, the code is 3'b100. Two infinities of the same sign are equal.
- R4: Positive and negative zero compare equal in either order, giving 3'b100.
- R5: In unordered mode (`ordered_i` = 0), a quiet NaN in either operand gives 3'b111 and does not raise `invalid_o`. A quiet NaN has exponent all ones, integer bit set and significand bit 62 set.
- R6: A signaling NaN in either operand raises `invalid_o`. A signaling NaN has exponent all ones, integer bit set, bit 62 clear and a nonzero fraction.
- R7: When invalid is raised and `inv_mask_i` = 1, the flags are written with 3'b111 and `flag_we_o` = 1.
- R8: When invalid is raised and `inv_mask_i` = 0, `flag_we_o` = 0 and `cc_o` keeps its previous value.
- R9: With `ordered_i` = 1, a NaN of either kind raises `invalid_o`. Ordinary numbers compare the same as in unordered mode.
- R10: Two encodings are unsupported and raise `invalid_o`: a nonzero exponent with the integer bit clear, and an all-ones exponent with the integer bit clear.
- R11: Denormals (exponent zero, nonzero significand) compare by magnitude and raise no exception.
- R12: Results appear one clock after the edge that samples `cmp_en_i` = 1, with `valid_o` high for that cycle. With `cmp_en_i` = 0, `valid_o` and `invalid_o` are low and `cc_o` holds.
- R13: After reset, `cc_o` = 3'b000 and `valid_o`, `invalid_o` and `flag_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_en_i | input | 1 | Evaluate the operands at this edge |
| op_a_i | input | 80 | Top-of-stack operand |
| op_b_i | input | 80 | Selected source operand |
| ordered_i | input | 1 | 1 selects ordered mode (any NaN is invalid) |
| inv_mask_i | input | 1 | Invalid-operand exception mask |
| cc_o | output | 3 | Condition code {C3,C2,C0} |
| invalid_o | output | 1 | Invalid-operand exception request |
| flag_we_o | output | 1 | Condition flags were written by this compare |
| valid_o | output | 1 | A compare result is present this cycle |

## Verification
All four outputs are due exactly one clock after the rising edge that samples `cmp_en_i` high. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a cycle after that capture. The hold case for an unmasked invalid first writes a known code. It then reads `cc_o` on the following cycle to confirm the code was not overwritten. The idle case drives an offending operand with `cmp_en_i` low and checks one cycle later that nothing moved.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned EXP_W = 15;
  localparam int unsigned SIG_W = 64;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_NORM,
    CLS_DENORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN,
    CLS_UNSUP
  } cls_e;

  localparam logic [2:0] CC_GT  = 3'b000;
  localparam logic [2:0] CC_LT  = 3'b001;
  localparam logic [2:0] CC_EQ  = 3'b100;
  localparam logic [2:0] CC_UNO = 3'b111;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = fcmp_pkg::EXP_W,
  parameter int unsigned SIG_W = fcmp_pkg::SIG_W,
  localparam int unsigned MAG_W = EXP_W + SIG_W,
  localparam int unsigned OP_W  = MAG_W + 1
) (
  input  logic [OP_W-1:0]  op_i,
  output cls_e             cls_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;
  logic             int_bit;
  logic             quiet_bit;
  logic             frac_nz;
  logic             exp_max;
  logic             exp_zero;

  assign sign_o    = op_i[OP_W-1];
  assign exp_f     = op_i[OP_W-2 -: EXP_W];
  assign sig_f     = op_i[SIG_W-1:0];
  assign mag_o     = op_i[MAG_W-1:0];
  assign int_bit   = sig_f[SIG_W-1];
  assign quiet_bit = sig_f[SIG_W-2];
  assign frac_nz   = |sig_f[SIG_W-2:0];
  assign exp_max   = &exp_f;
  assign exp_zero  = ~|exp_f;

  always_comb begin
    if (exp_zero) begin
      cls_o = (|sig_f) ? CLS_DENORM : CLS_ZERO;
    end else if (!int_bit) begin
      cls_o = CLS_UNSUP;  // unnormal, pseudo-NaN, pseudo-infinity
    end else if (exp_max) begin
      if (!frac_nz)      cls_o = CLS_INF;
      else if (quiet_bit) cls_o = CLS_QNAN;
      else               cls_o = CLS_SNAN;
    end else begin
      cls_o = CLS_NORM;
    end
  end
endmodule

// File: rtl/fcmp_mag_cmp.sv
module fcmp_mag_cmp #(
  parameter int unsigned W       = 79,
  parameter int unsigned CHUNK_W = 16,
  localparam int unsigned NCH    = (W + CHUNK_W - 1) / CHUNK_W,
  localparam int unsigned PW     = NCH * CHUNK_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         eq_o
);
  logic [PW-1:0]  a_pad;
  logic [PW-1:0]  b_pad;
  logic [NCH-1:0] c_gt;
  logic [NCH-1:0] c_eq;

  assign a_pad = PW'(a_i);
  assign b_pad = PW'(b_i);

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign c_gt[g] = a_pad[g*CHUNK_W +: CHUNK_W] > b_pad[g*CHUNK_W +: CHUNK_W];
    assign c_eq[g] = a_pad[g*CHUNK_W +: CHUNK_W] == b_pad[g*CHUNK_W +: CHUNK_W];
  end

  // most significant differing chunk decides
  always_comb begin
    gt_o = 1'b0;
    eq_o = 1'b1;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eq_o) begin
        gt_o = c_gt[i];
        eq_o = c_eq[i];
      end
    end
  end
endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide
  import fcmp_pkg::*;
(
  input  cls_e       cls_a_i,
  input  cls_e       cls_b_i,
  input  logic       sign_a_i,
  input  logic       sign_b_i,
  input  logic       mag_gt_i,
  input  logic       mag_eq_i,
  input  logic       ordered_i,
  input  logic       inv_mask_i,
  output logic [2:0] cc_o,
  output logic       invalid_o,
  output logic       flag_we_o
);
  logic nan_a, nan_b, bad_a, bad_b, unord, both_zero, a_wins;

  assign nan_a     = (cls_a_i == CLS_QNAN) || (cls_a_i == CLS_SNAN);
  assign nan_b     = (cls_b_i == CLS_QNAN) || (cls_b_i == CLS_SNAN);
  assign bad_a     = (cls_a_i == CLS_SNAN) || (cls_a_i == CLS_UNSUP);
  assign bad_b     = (cls_b_i == CLS_SNAN) || (cls_b_i == CLS_UNSUP);
  assign unord     = nan_a | nan_b | bad_a | bad_b;
  assign both_zero = (cls_a_i == CLS_ZERO) && (cls_b_i == CLS_ZERO);
  assign invalid_o = bad_a | bad_b | (ordered_i & (nan_a | nan_b));
  assign flag_we_o = ~invalid_o | inv_mask_i;
  assign a_wins    = mag_gt_i ^ sign_a_i;  // same sign: negative flips order

  always_comb begin
    if (unord)                 cc_o = CC_UNO;
    else if (both_zero)        cc_o = CC_EQ;
    else if (sign_a_i != sign_b_i) cc_o = sign_a_i ? CC_LT : CC_GT;
    else if (mag_eq_i)         cc_o = CC_EQ;
    else                       cc_o = a_wins ? CC_GT : CC_LT;
  end
endmodule

// File: rtl/fcmp_unordered.sv
module fcmp_unordered
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W   = fcmp_pkg::EXP_W,
  parameter int unsigned SIG_W   = fcmp_pkg::SIG_W,
  parameter int unsigned CHUNK_W = 16,
  localparam int unsigned MAG_W  = EXP_W + SIG_W,
  localparam int unsigned OP_W   = MAG_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmp_en_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  input  logic            ordered_i,
  input  logic            inv_mask_i,
  output logic [2:0]      cc_o,
  output logic            invalid_o,
  output logic            flag_we_o,
  output logic            valid_o
);
  cls_e             cls_a, cls_b;
  logic             sign_a, sign_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             mag_gt, mag_eq;
  logic [2:0]       cc_d;
  logic             inv_d, we_d;

  fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_a (
    .op_i(op_a_i), .cls_o(cls_a), .sign_o(sign_a), .mag_o(mag_a)
  );

  fcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_b (
    .op_i(op_b_i), .cls_o(cls_b), .sign_o(sign_b), .mag_o(mag_b)
  );

  fcmp_mag_cmp #(.W(MAG_W), .CHUNK_W(CHUNK_W)) u_mag (
    .a_i(mag_a), .b_i(mag_b), .gt_o(mag_gt), .eq_o(mag_eq)
  );

  fcmp_decide u_dec (
    .cls_a_i(cls_a), .cls_b_i(cls_b), .sign_a_i(sign_a), .sign_b_i(sign_b),
    .mag_gt_i(mag_gt), .mag_eq_i(mag_eq), .ordered_i(ordered_i),
    .inv_mask_i(inv_mask_i), .cc_o(cc_d), .invalid_o(inv_d), .flag_we_o(we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_o      <= CC_GT;
      invalid_o <= 1'b0;
      flag_we_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o   <= cmp_en_i;
      invalid_o <= cmp_en_i & inv_d;
      flag_we_o <= cmp_en_i & we_d;
      if (cmp_en_i && we_d) cc_o <= cc_d;
    end
  end

  logic any_q, any_bad;
  assign any_q   = (cls_a == CLS_QNAN) || (cls_b == CLS_QNAN);
  assign any_bad = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN) ||
                   (cls_a == CLS_UNSUP) || (cls_b == CLS_UNSUP);

  p_cc_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_o == CC_GT) || (cc_o == CC_LT) || (cc_o == CC_EQ) || (cc_o == CC_UNO));

  p_zero_eq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO) |=> cc_o == CC_EQ);

  p_qnan_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && !ordered_i && any_q && !any_bad |=> !invalid_o && cc_o == CC_UNO);

  p_bad_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && any_bad |=> invalid_o);

  p_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && any_bad && inv_mask_i |=> flag_we_o && cc_o == CC_UNO);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && any_bad && !inv_mask_i |=> !flag_we_o && $stable(cc_o));

  p_ord_nan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && ordered_i && any_q |=> invalid_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> !valid_o && !invalid_o && !flag_we_o && $stable(cc_o));
endmodule

// File: tb/fcmp_unordered_tb.sv
`timescale 1ns/1ps
module fcmp_unordered_tb;
  typedef struct packed {
    logic [79:0] a;
    logic [79:0] b;
    logic        ord;
    logic        mask;
    logic [2:0]  cc;
    logic        inv;
    logic        we;
    logic [3:0]  req;
  } vec_t;

  localparam logic [79:0] P1   = 80'h3FFF_8000000000000000;
  localparam logic [79:0] P2   = 80'h4000_8000000000000000;
  localparam logic [79:0] N1   = 80'hBFFF_8000000000000000;
  localparam logic [79:0] N2   = 80'hC000_8000000000000000;
  localparam logic [79:0] PZ   = 80'h0000_0000000000000000;
  localparam logic [79:0] NZ   = 80'h8000_0000000000000000;
  localparam logic [79:0] PINF = 80'h7FFF_8000000000000000;
  localparam logic [79:0] NINF = 80'hFFFF_8000000000000000;
  localparam logic [79:0] QN   = 80'h7FFF_C000000000000000;
  localparam logic [79:0] SN   = 80'h7FFF_A000000000000000;
  localparam logic [79:0] UNN  = 80'h3FFF_4000000000000000;
  localparam logic [79:0] PINV = 80'h7FFF_0000000000000000;
  localparam logic [79:0] DS   = 80'h0000_0000000000000001;
  localparam logic [79:0] DB   = 80'h0000_0000000000000010;
  localparam logic [79:0] NDS  = 80'h8000_0000000000000001;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    {P2,  P1,  1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 4'd1},   // R1
    {N1,  N2,  1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 4'd1},   // R1
    {NZ,  N1,  1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 4'd1},   // R1
    {P1,  P2,  1'b0, 1'b0, 3'b001, 1'b0, 1'b1, 4'd2},   // R2
    {N2,  N1,  1'b0, 1'b0, 3'b001, 1'b0, 1'b1, 4'd2},   // R2
    {N1,  P1,  1'b0, 1'b0, 3'b001, 1'b0, 1'b1, 4'd2},   // R2
    {NINF,PZ,  1'b0, 1'b0, 3'b001, 1'b0, 1'b1, 4'd2},   // R2
    {P1,  P1,  1'b0, 1'b0, 3'b100, 1'b0, 1'b1, 4'd3},   // R3
    {PINF,PINF,1'b0, 1'b0, 3'b100, 1'b0, 1'b1, 4'd3},   // R3
    {PZ,  NZ,  1'b0, 1'b0, 3'b100, 1'b0, 1'b1, 4'd4},   // R4
    {NZ,  PZ,  1'b0, 1'b0, 3'b100, 1'b0, 1'b1, 4'd4},   // R4
    {QN,  P1,  1'b0, 1'b0, 3'b111, 1'b0, 1'b1, 4'd5},   // R5
    {P1,  QN,  1'b0, 1'b0, 3'b111, 1'b0, 1'b1, 4'd5},   // R5
    {P1,  SN,  1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 4'd6},   // R6
    {QN,  SN,  1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 4'd6},   // R6
    {SN,  P1,  1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 4'd7},   // R7
    {QN,  P1,  1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 4'd9},   // R9
    {P1,  P2,  1'b1, 1'b0, 3'b001, 1'b0, 1'b1, 4'd9},   // R9
    {UNN, P1,  1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 4'd10},  // R10
    {PINV,P1,  1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 4'd10},  // R10
    {DB,  DS,  1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 4'd11},  // R11
    {NDS, PZ,  1'b0, 1'b0, 3'b001, 1'b0, 1'b1, 4'd11},  // R11
    {P1,  DB,  1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 4'd11}   // R11
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_en_i = 1'b0;
  logic [79:0] op_a_i = '0;
  logic [79:0] op_b_i = '0;
  logic        ordered_i = 1'b0;
  logic        inv_mask_i = 1'b0;
  logic [2:0]  cc_o;
  logic        invalid_o, flag_we_o, valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fcmp_unordered u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_en_i(cmp_en_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .ordered_i(ordered_i), .inv_mask_i(inv_mask_i),
    .cc_o(cc_o), .invalid_o(invalid_o), .flag_we_o(flag_we_o), .valid_o(valid_o)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s {cc,inv,we,vld} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [79:0] a, input logic [79:0] b,
                       input logic ord, input logic mask, input logic en);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; ordered_i = ord; inv_mask_i = mask; cmp_en_i = en;
    @(negedge clk_i);
    cmp_en_i = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R13 reset", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b000_000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].a, TBL[i].b, TBL[i].ord, TBL[i].mask, 1'b1);
      check($sformatf("R%0d row %0d", TBL[i].req, i),
            {cc_o, invalid_o, flag_we_o, valid_o},
            {TBL[i].cc, TBL[i].inv, TBL[i].we, 1'b1});
    end

    // R8: set a known code, then unmasked invalid must leave it
    drive(P1, P2, 1'b0, 1'b0, 1'b1);
    check("R8 setup", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b001_011);
    drive(SN, P1, 1'b0, 1'b0, 1'b1);
    check("R8 snan unmasked", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b001_101);
    drive(UNN, P1, 1'b0, 1'b0, 1'b1);
    check("R8 unsupported unmasked", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b001_101);
    drive(QN, P1, 1'b1, 1'b0, 1'b1);
    check("R8 ordered qnan unmasked", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b001_101);

    // R12: idle with offending operands does nothing
    drive(SN, QN, 1'b1, 1'b1, 1'b0);
    check("R12 idle", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b001_000);
    drive(P2, P1, 1'b0, 1'b0, 1'b0);
    check("R12 idle hold", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b001_000);

    // R13: reset mid-run returns to reset state
    drive(PZ, PZ, 1'b0, 1'b0, 1'b1);
    check("R4 zeros", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b100_011);
    rst_ni = 1'b0;
    #1;
    check("R13 async reset", {cc_o, invalid_o, flag_we_o, valid_o}, 6'b000_000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule